// File: doc/BRIEF.md
# Triggered Differential Dual-Rate Capture

This block takes two signed sample streams that both arrive on every clock, subtracts the second from the first, and records the result into two on-chip sample buffers once a trigger occurs. The first buffer keeps one difference sample out of every 2^k, where k is chosen by software. The second buffer keeps every difference sample at the full rate, whatever k is set to. It records one buffer's worth of samples and then stops, so the earlier data is never overwritten.

Software controls the block through a small register port. It selects the trigger source, sets the decimation exponent and the level threshold, and arms the block. It then polls a done flag and two fill counters. The trigger is either an external pulse that arrives with the samples, or a rising crossing of the difference past a programmable level. After done, software reads both buffers through their own registered read ports. A single shot can therefore be read back both as a decimated overview and as a full-rate window starting at the trigger.

Top module: `dual_rate_diff_capture`

## Requirements
- R1: The stored value is channel A minus channel B, held with one bit more than the inputs, so full-scale opposite inputs (+8191 − (−8192) and −8192 − 8191 at 14 bits) are stored exactly as +16383 and −16383.
- R2: With the source bit at 0, the trigger is the external input presented in the same cycle as a sample. Full-rate buffer address k then holds the difference of the sample presented k cycles after the trigger sample, with address 0 holding the trigger sample itself.
- R3: The full-rate buffer takes exactly FULL_DEPTH samples per shot and then stops, independent of the decimation setting. The full-rate fill count (register address 4) then reads FULL_DEPTH.
- R4: Decimated buffer address k holds the difference of the sample presented k·2^s cycles after the trigger sample, where s is the decimation exponent (register address 1). It takes DEC_DEPTH samples per shot, and its fill count is at register address 3.
- R5: The decimation exponent accepts 0 through MAX_SHIFT (16, giving factors 1 to 65536). A written value above MAX_SHIFT is stored and read back as MAX_SHIFT.
- R6: With the source bit at 1, the trigger fires on the first sample whose difference is at or above the signed threshold (register address 2) while the previous sample's difference was below it. A downward crossing does not fire.
- R7: Trigger events that arrive while the block is not armed (before arming or after done) are ignored. Buffer contents, fill counts and the done flag stay unchanged.
- R8: The done flag sets once both captures of a shot have finished and then holds. Writing the arm bit clears done and both fill counts, sets armed, and stops any capture in progress. Armed, done and capturing are never true together.
- R9: The status register (address 0) reads bit 0 done, bit 1 armed, bit 2 capturing and bit 3 source. Writing address 0 takes bit 0 as the arm command and bit 1 as the source (0 = external, 1 = level). After reset, status, fill counts, exponent and threshold all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_a | input | SAMPLE_W | Channel A sample, signed, one per clock |
| ch_b | input | SAMPLE_W | Channel B sample, signed, one per clock |
| ext_trig | input | 1 | External trigger, qualified with the sample of the same cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dec_raddr | input | log2(DEC_DEPTH) | Decimated buffer read address |
| dec_rdata | output | SAMPLE_W+1 | Decimated buffer data, one cycle after address |
| full_raddr | input | log2(FULL_DEPTH) | Full-rate buffer read address |
| full_rdata | output | SAMPLE_W+1 | Full-rate buffer data, one cycle after address |

## Verification
The assertions assume that register writes are single-cycle strobes. They also assume software sets the exponent and source before arming, so an arm write is the only event that may interrupt a shot or restart the counters. The properties on count stepping, count bounds and state exclusivity therefore exempt only the cycle after an arm write. The bench issues every register write as a one-cycle strobe at a falling edge. It changes the exponent and threshold only while the block is done or idle. It drives samples and the external pulse together at falling edges, so each pulse is tied to exactly one sample.

// File: rtl/dcap_pkg.sv
// Shared register map and control-bit positions for the differential capture block.
package dcap_pkg;
    localparam int          REG_AW        = 3;
    localparam logic [2:0]  ADDR_CTRL     = 3'd0;
    localparam logic [2:0]  ADDR_SHIFT    = 3'd1;
    localparam logic [2:0]  ADDR_THRESH   = 3'd2;
    localparam logic [2:0]  ADDR_DEC_CNT  = 3'd3;
    localparam logic [2:0]  ADDR_FULL_CNT = 3'd4;
    localparam int          CTL_ARM_BIT   = 0;
    localparam int          CTL_SRC_BIT   = 1;
endpackage

// File: rtl/diff_front.sv
// Input stage: registers A - B at one extra bit of width, keeps the previous
// difference for edge detection, and delays the external trigger by the same
// single cycle so that pulse and sample stay aligned.
// Assumes: inputs are synchronous to clk.
module diff_front #(
    parameter int SAMPLE_W = 14,
    localparam int DIFF_W  = SAMPLE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      ch_a,
    input  logic [SAMPLE_W-1:0]      ch_b,
    input  logic                     ext_trig,
    output logic signed [DIFF_W-1:0] diff_q,
    output logic signed [DIFF_W-1:0] diff_prev,
    output logic                     ext_q
);
    logic signed [DIFF_W-1:0] a_ext, b_ext;

    // Sign-extend both channels by one bit.
    always_comb begin
        a_ext = {ch_a[SAMPLE_W-1], ch_a};
        b_ext = {ch_b[SAMPLE_W-1], ch_b};
    end

    // Register the difference, its predecessor and the aligned trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q    <= '0;
            diff_prev <= '0;
            ext_q     <= 1'b0;
        end else begin
            diff_q    <= a_ext - b_ext;
            diff_prev <= diff_q;
            ext_q     <= ext_trig;
        end
    end
endmodule

// File: rtl/trig_detect.sv
// Trigger selection: external pulse, or rising crossing of a signed level.
// Assumes: diff_prev is the sample immediately before diff_q.
module trig_detect #(
    parameter int DIFF_W = 15
) (
    input  logic                     src_level,
    input  logic signed [DIFF_W-1:0] thresh,
    input  logic signed [DIFF_W-1:0] diff_q,
    input  logic signed [DIFF_W-1:0] diff_prev,
    input  logic                     ext_q,
    output logic                     hit
);
    // Pick the active source; level fires only on an upward crossing.
    always_comb begin
        if (src_level) hit = (diff_prev < thresh) && (diff_q >= thresh);
        else           hit = ext_q;
    end
endmodule

// File: rtl/capture_ctrl.sv
// Shot controller: on an armed trigger it writes the trigger sample into both
// buffers, then fills the full-rate buffer every cycle and the decimated buffer
// every 2^shift cycles, stopping each at its depth; done follows both stops.
// Assumes: depths are at least 2; shift <= MAX_SHIFT.
module capture_ctrl #(
    parameter int  DEC_DEPTH  = 1024,
    parameter int  FULL_DEPTH = 1024,
    parameter int  MAX_SHIFT  = 16,
    localparam int SH_W = $clog2(MAX_SHIFT + 1),
    localparam int DA_W = $clog2(DEC_DEPTH),
    localparam int FA_W = $clog2(FULL_DEPTH),
    localparam int DC_W = $clog2(DEC_DEPTH + 1),
    localparam int FC_W = $clog2(FULL_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            hit,
    input  logic [SH_W-1:0] shift,
    output logic            armed,
    output logic            done,
    output logic            busy_full,
    output logic            busy_dec,
    output logic [FC_W-1:0] full_cnt,
    output logic [DC_W-1:0] dec_cnt,
    output logic            full_we,
    output logic [FA_W-1:0] full_waddr,
    output logic            dec_we,
    output logic [DA_W-1:0] dec_waddr
);
    localparam logic [FC_W-1:0] FULL_LAST = FC_W'(FULL_DEPTH - 1);
    localparam logic [DC_W-1:0] DEC_LAST  = DC_W'(DEC_DEPTH - 1);

    logic                 started;
    logic                 fire;
    logic                 dec_tick;
    logic [MAX_SHIFT-1:0] phase;
    logic [MAX_SHIFT-1:0] mask;

    // Decode trigger acceptance, decimation tick and buffer write strobes.
    always_comb begin
        mask       = ~({MAX_SHIFT{1'b1}} << shift);
        fire       = armed && hit && !arm;
        dec_tick   = (phase & mask) == '0;
        full_we    = fire || busy_full;
        full_waddr = fire ? '0 : full_cnt[FA_W-1:0];
        dec_we     = fire || (busy_dec && dec_tick);
        dec_waddr  = fire ? '0 : dec_cnt[DA_W-1:0];
    end

    // Sequence arm, trigger, fill and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            done      <= 1'b0;
            started   <= 1'b0;
            busy_full <= 1'b0;
            busy_dec  <= 1'b0;
            full_cnt  <= '0;
            dec_cnt   <= '0;
            phase     <= '0;
        end else if (arm) begin
            armed     <= 1'b1;
            done      <= 1'b0;
            started   <= 1'b0;
            busy_full <= 1'b0;
            busy_dec  <= 1'b0;
            full_cnt  <= '0;
            dec_cnt   <= '0;
            phase     <= '0;
        end else if (fire) begin
            armed     <= 1'b0;
            started   <= 1'b1;
            busy_full <= 1'b1;
            busy_dec  <= 1'b1;
            full_cnt  <= FC_W'(1);
            dec_cnt   <= DC_W'(1);
            phase     <= MAX_SHIFT'(1);
        end else begin
            if (busy_full) begin
                full_cnt <= full_cnt + 1'b1;
                if (full_cnt == FULL_LAST) busy_full <= 1'b0;
            end
            if (busy_dec) begin
                phase <= phase + 1'b1;
                if (dec_tick) begin
                    dec_cnt <= dec_cnt + 1'b1;
                    if (dec_cnt == DEC_LAST) busy_dec <= 1'b0;
                end
            end
            if (started && !busy_full && !busy_dec) begin
                done    <= 1'b1;
                started <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sample_ram.sv
// Simple dual-port sample store: one write port, one registered read port.
// Assumes: no read-during-write ordering is required by the user.
module sample_ram #(
    parameter int  WIDTH = 15,
    parameter int  DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write on strobe, read one cycle after address.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dual_rate_diff_capture.sv
// Top: register port, difference front end, trigger select, shot controller and
// the two sample buffers (decimated and full-rate).
// Assumes: register writes are single-cycle strobes; exponent and source are
// set before arming.
module dual_rate_diff_capture
    import dcap_pkg::*;
#(
    parameter int  SAMPLE_W   = 14,
    parameter int  DEC_DEPTH  = 1024,
    parameter int  FULL_DEPTH = 1024,
    parameter int  MAX_SHIFT  = 16,
    localparam int DIFF_W = SAMPLE_W + 1,
    localparam int SH_W   = $clog2(MAX_SHIFT + 1),
    localparam int DA_W   = $clog2(DEC_DEPTH),
    localparam int FA_W   = $clog2(FULL_DEPTH),
    localparam int DC_W   = $clog2(DEC_DEPTH + 1),
    localparam int FC_W   = $clog2(FULL_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SAMPLE_W-1:0]   ch_a,
    input  logic [SAMPLE_W-1:0]   ch_b,
    input  logic                  ext_trig,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [DA_W-1:0]       dec_raddr,
    output logic [DIFF_W-1:0]     dec_rdata,
    input  logic [FA_W-1:0]       full_raddr,
    output logic [DIFF_W-1:0]     full_rdata
);
    logic signed [DIFF_W-1:0] diff_q, diff_prev, thr_q;
    logic                     ext_q, hit, arm_cmd, src_q;
    logic [SH_W-1:0]          shift_q;
    logic                     cap_armed, cap_done, cap_busy_full, cap_busy_dec;
    logic [FC_W-1:0]          full_cnt;
    logic [DC_W-1:0]          dec_cnt;
    logic                     full_we, dec_we;
    logic [FA_W-1:0]          full_waddr;
    logic [DA_W-1:0]          dec_waddr;

    // Arm command is a write to the control address with the arm bit set.
    always_comb arm_cmd = reg_we && (reg_addr == ADDR_CTRL) && reg_wdata[CTL_ARM_BIT];

    // Configuration registers; the exponent saturates at MAX_SHIFT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= 1'b0;
            shift_q <= '0;
            thr_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL:   src_q   <= reg_wdata[CTL_SRC_BIT];
                ADDR_SHIFT:  shift_q <= (reg_wdata > 32'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT)
                                                                     : reg_wdata[SH_W-1:0];
                ADDR_THRESH: thr_q   <= reg_wdata[DIFF_W-1:0];
                default:     ;
            endcase
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL:     reg_rdata = {28'd0, src_q, cap_busy_full | cap_busy_dec,
                                        cap_armed, cap_done};
            ADDR_SHIFT:    reg_rdata = 32'(shift_q);
            ADDR_THRESH:   reg_rdata = {{(32-DIFF_W){thr_q[DIFF_W-1]}}, thr_q};
            ADDR_DEC_CNT:  reg_rdata = 32'(dec_cnt);
            ADDR_FULL_CNT: reg_rdata = 32'(full_cnt);
            default:       reg_rdata = '0;
        endcase
    end

    diff_front #(.SAMPLE_W(SAMPLE_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .ext_trig(ext_trig),
        .diff_q(diff_q), .diff_prev(diff_prev), .ext_q(ext_q)
    );

    trig_detect #(.DIFF_W(DIFF_W)) u_trig (
        .src_level(src_q), .thresh(thr_q), .diff_q(diff_q),
        .diff_prev(diff_prev), .ext_q(ext_q), .hit(hit)
    );

    capture_ctrl #(.DEC_DEPTH(DEC_DEPTH), .FULL_DEPTH(FULL_DEPTH), .MAX_SHIFT(MAX_SHIFT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm_cmd), .hit(hit), .shift(shift_q),
        .armed(cap_armed), .done(cap_done), .busy_full(cap_busy_full), .busy_dec(cap_busy_dec),
        .full_cnt(full_cnt), .dec_cnt(dec_cnt),
        .full_we(full_we), .full_waddr(full_waddr), .dec_we(dec_we), .dec_waddr(dec_waddr)
    );

    sample_ram #(.WIDTH(DIFF_W), .DEPTH(DEC_DEPTH)) u_dec_buf (
        .clk(clk), .we(dec_we), .waddr(dec_waddr), .wdata(diff_q),
        .raddr(dec_raddr), .rdata(dec_rdata)
    );

    sample_ram #(.WIDTH(DIFF_W), .DEPTH(FULL_DEPTH)) u_full_buf (
        .clk(clk), .we(full_we), .waddr(full_waddr), .wdata(diff_q),
        .raddr(full_raddr), .rdata(full_rdata)
    );
endmodule

// File: rtl/dcap_checker.sv
// Property checker for the capture controller state and the register port.
// Assumes: bound to dual_rate_diff_capture, sharing its clock and reset.
module dcap_checker #(
    parameter int  DEC_DEPTH  = 1024,
    parameter int  FULL_DEPTH = 1024,
    parameter int  MAX_SHIFT  = 16,
    localparam int SH_W = $clog2(MAX_SHIFT + 1),
    localparam int DC_W = $clog2(DEC_DEPTH + 1),
    localparam int FC_W = $clog2(FULL_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [2:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            st_done,
    input logic            st_armed,
    input logic            busy_full,
    input logic            busy_dec,
    input logic [FC_W-1:0] full_cnt,
    input logic [DC_W-1:0] dec_cnt,
    input logic [SH_W-1:0] shift
);
    logic arm_wr;
    always_comb arm_wr = reg_we && (reg_addr == 3'd0) && reg_wdata[0];

    // R3: full-rate fill never exceeds its capacity.
    p_full_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_cnt <= FC_W'(FULL_DEPTH));

    // R3: while filling, exactly one full-rate sample is taken per cycle.
    p_full_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_full && !arm_wr) |=> (full_cnt == $past(full_cnt) + 1'b1));

    // R4: decimated fill never exceeds its capacity.
    p_dec_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cnt <= DC_W'(DEC_DEPTH));

    // R5: stored exponent stays in range.
    p_shift_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift <= SH_W'(MAX_SHIFT));

    // R7: when neither armed nor capturing, fill counts do not move.
    p_idle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_armed && !busy_full && !busy_dec && !arm_wr)
            |=> ($stable(full_cnt) && $stable(dec_cnt)));

    // R8: armed, done and capturing are mutually exclusive.
    p_state_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_done, st_armed, busy_full | busy_dec}));

    // R8: done holds until re-armed.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !arm_wr) |=> st_done);
endmodule

bind dual_rate_diff_capture dcap_checker #(
    .DEC_DEPTH(DEC_DEPTH), .FULL_DEPTH(FULL_DEPTH), .MAX_SHIFT(MAX_SHIFT)
) u_dcap_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .st_done(cap_done), .st_armed(cap_armed), .busy_full(cap_busy_full),
    .busy_dec(cap_busy_dec), .full_cnt(full_cnt), .dec_cnt(dec_cnt), .shift(shift_q)
);

// File: tb/tb_dual_rate_diff_capture.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dual_rate_diff_capture;
    localparam int SW   = 14;
    localparam int DW   = SW + 1;
    localparam int DDEP = 8;
    localparam int FDEP = 16;
    localparam int MSH  = 16;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [SW-1:0]              ch_a = '0, ch_b = '0;
    logic                       ext_trig = 1'b0;
    logic                       reg_we = 1'b0;
    logic [2:0]                 reg_addr = '0;
    logic [31:0]                reg_wdata = '0;
    logic [31:0]                reg_rdata;
    logic [$clog2(DDEP)-1:0]    dec_raddr = '0;
    logic [DW-1:0]              dec_rdata;
    logic [$clog2(FDEP)-1:0]    full_raddr = '0;
    logic [DW-1:0]              full_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    dual_rate_diff_capture #(
        .SAMPLE_W(SW), .DEC_DEPTH(DDEP), .FULL_DEPTH(FDEP), .MAX_SHIFT(MSH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .ext_trig(ext_trig),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dec_raddr(dec_raddr), .dec_rdata(dec_rdata),
        .full_raddr(full_raddr), .full_rdata(full_rdata)
    );

    function automatic int val_a(int mode, int i);
        if (mode == 0) return i - 100;
        return (i % 2 == 0) ? 8191 : -8192;
    endfunction
    function automatic int val_b(int mode, int i);
        if (mode == 0) return 50 - 2 * i;
        return (i % 2 == 0) ? -8192 : 8191;
    endfunction
    function automatic int exp_diff(int mode, int i);
        return val_a(mode, i) - val_b(mode, i);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic rd_full(int k, output int d);
        @(negedge clk);
        full_raddr = k[$clog2(FDEP)-1:0];
        @(negedge clk);
        d = int'($signed(full_rdata));
    endtask

    task automatic rd_dec(int k, output int d);
        @(negedge clk);
        dec_raddr = k[$clog2(DDEP)-1:0];
        @(negedge clk);
        d = int'($signed(dec_rdata));
    endtask

    // Drive n samples; ext pulse with sample trig_at (negative: none).
    task automatic stream(int mode, int n, int trig_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ch_a = SW'(val_a(mode, i));
            ch_b = SW'(val_b(mode, i));
            ext_trig = (i == trig_at);
        end
        @(negedge clk);
        ext_trig = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        int d;
        reg_rd(3'd0, d); chk("R9 status after reset", d, 0);
        reg_rd(3'd1, d); chk("R9 exponent after reset", d, 0);
        reg_rd(3'd3, d); chk("R9 dec count after reset", d, 0);
        reg_rd(3'd4, d); chk("R9 full count after reset", d, 0);
    endtask

    task automatic test_ext_full_rate();
        int d;
        reg_wr(3'd1, 0);
        reg_wr(3'd0, 1);                       // arm, external source
        reg_rd(3'd0, d); chk("R9 armed bit", d, 2);
        stream(0, 40, 5);
        reg_rd(3'd0, d); chk("R8 done after shot", d, 1);
        reg_rd(3'd4, d); chk("R3 full count", d, FDEP);
        reg_rd(3'd3, d); chk("R4 dec count", d, DDEP);
        for (int k = 0; k < FDEP; k++) begin
            rd_full(k, d); chk("R2 full-rate sample", d, exp_diff(0, 5 + k));
        end
        for (int k = 0; k < DDEP; k++) begin
            rd_dec(k, d); chk("R4 dec sample N=1", d, exp_diff(0, 5 + k));
        end
    endtask

    task automatic test_ignore_when_done();
        int d;
        stream(0, 30, 3);                      // pulse while done
        reg_rd(3'd0, d); chk("R7 done unchanged", d, 1);
        reg_rd(3'd4, d); chk("R7 full count unchanged", d, FDEP);
        rd_full(0, d);   chk("R7 full[0] unchanged", d, exp_diff(0, 5));
    endtask

    task automatic test_decimate4();
        int d;
        reg_wr(3'd1, 2);
        reg_wr(3'd0, 1);
        stream(0, 50, 7);
        reg_rd(3'd0, d); chk("R8 done after N=4 shot", d, 1);
        for (int k = 0; k < DDEP; k++) begin
            rd_dec(k, d); chk("R4 dec sample N=4", d, exp_diff(0, 7 + 4 * k));
        end
        rd_full(FDEP - 1, d); chk("R3 full-rate ignores decimation", d, exp_diff(0, 7 + FDEP - 1));
    endtask

    task automatic test_extremes();
        int d;
        reg_wr(3'd1, 0);
        reg_wr(3'd0, 1);
        stream(1, 24, 0);
        rd_full(0, d); chk("R1 positive extreme", d, 16383);
        rd_full(1, d); chk("R1 negative extreme", d, -16383);
        rd_dec(2, d);  chk("R1 dec extreme", d, 16383);
    endtask

    task automatic test_max_shift_and_rearm();
        int d;
        reg_wr(3'd1, 31);
        reg_rd(3'd1, d); chk("R5 exponent clamps", d, MSH);
        reg_wr(3'd1, 16);
        reg_rd(3'd1, d); chk("R5 exponent max accepted", d, MSH);
        reg_wr(3'd0, 1);
        stream(0, 40, 2);
        reg_rd(3'd4, d); chk("R3 full stops at depth with N=65536", d, FDEP);
        reg_rd(3'd3, d); chk("R4 one dec sample so far", d, 1);
        reg_rd(3'd0, d); chk("R8 still capturing", d, 4);
        rd_full(0, d);   chk("R2 trigger sample with N=65536", d, exp_diff(0, 2));
        reg_wr(3'd0, 1);
        reg_rd(3'd0, d); chk("R8 re-arm stops shot", d, 2);
        reg_rd(3'd3, d); chk("R8 re-arm clears dec count", d, 0);
        reg_rd(3'd4, d); chk("R8 re-arm clears full count", d, 0);
    endtask

    task automatic test_level();
        int d;
        reg_wr(3'd1, 0);
        reg_wr(3'd2, 0);
        reg_wr(3'd0, 3);                       // arm, level source
        reg_rd(3'd0, d); chk("R9 source bit", d, 10);
        stream(0, 90, -1);                     // rises through 0 at sample 50
        reg_rd(3'd0, d); chk("R6 done after level shot", d, 9);
        rd_full(0, d);  chk("R6 trigger at crossing", d, exp_diff(0, 50));
        rd_full(9, d);  chk("R6 full sample after crossing", d, exp_diff(0, 59));
        rd_dec(7, d);   chk("R6 dec sample after crossing", d, exp_diff(0, 57));
        reg_wr(3'd2, 30);
        stream(0, 90, -1);                     // crossing at 60 while done
        rd_full(0, d);  chk("R7 level ignored when done", d, exp_diff(0, 50));
        reg_rd(3'd0, d); chk("R7 status unchanged", d, 9);
        reg_rd(3'd2, d); chk("R6 threshold readback", d, 30);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_ext_full_rate();
        test_ignore_when_done();
        test_decimate4();
        test_extremes();
        test_max_shift_and_rearm();
        test_level();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule